// File: doc/BRIEF.md
# Rock-Paper-Scissors Judge

A purely combinational referee for a two-player round of rock-paper-scissors. Each player presents a move as three one-hot bits. The judge first validates and compresses each move into a 2-bit code with an error flag. It then compares the two codes for a tie and evaluates one win function for player A. Player B's win is the inverse of that function.

Each player has three indicator outputs: red, green and blue. Red shows an illegal entry on that side and is never gated, so a player sees it while still choosing. Green and blue show the outcome. They light only while the reveal input is high and both entries are legal. The block holds no state, and its outputs follow the inputs within the same cycle.

Top module: `rps_judge`

## Requirements
- R1: Move bit 0 is rock, bit 1 is paper and bit 2 is scissors. A legal move is compressed to a 2-bit code: rock 00, paper 01, scissors 11. The code 10 is never produced for a legal move.
- R2: A side's red output is high exactly when that side's three move bits are not exactly one-hot, and it does not depend on reveal_i.
- R3: While reveal_i is low, all four green and blue outputs are low.
- R4: While either side's move is illegal, no green or blue output lights on either side, even with reveal_i high.
- R5: With both moves legal, equal and revealed, both blue outputs are high and both green outputs are low.
- R6: With both moves legal, different and revealed, the winner's green is high and the loser's green is low. Rock beats scissors, paper beats rock and scissors beats paper. Both blues are low.
- R7: At most one green output is ever high. Exactly one is high whenever both moves are legal, different and revealed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_move_i | input | 3 | Player A move, one-hot: [0] rock, [1] paper, [2] scissors |
| b_move_i | input | 3 | Player B move, same bit layout |
| reveal_i | input | 1 | High to show the green and blue outcome outputs |
| a_red_o | output | 1 | Player A entry is illegal |
| a_green_o | output | 1 | Player A wins |
| a_blue_o | output | 1 | Round is a tie (player A side) |
| b_red_o | output | 1 | Player B entry is illegal |
| b_green_o | output | 1 | Player B wins |
| b_blue_o | output | 1 | Round is a tie (player B side) |

## Verification
The hardest cases to reach are those where one side is legal and the other is not while reveal is high. In these cases the win and tie terms can still be true, and only the legality gate keeps green and blue dark. The same applies to zero-hot and multi-hot entries that happen to compress into the same code as a legal move. The stimulus covers all of these by sweeping all 64 move pairs at both reveal levels. Each combination is held for one clock, and every output is compared against a rule table computed from move indices. The two legal-but-tied and legal-but-different classes are both visited in every pass.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int MOVE_W       = 3;
  localparam int CODE_W       = 2;
  localparam int IDX_ROCK     = 0;
  localparam int IDX_PAPER    = 1;
  localparam int IDX_SCISSORS = 2;
  localparam int N_SIDES      = 2;

  localparam logic [CODE_W-1:0] CODE_ROCK     = 2'b00;
  localparam logic [CODE_W-1:0] CODE_PAPER    = 2'b01;
  localparam logic [CODE_W-1:0] CODE_SCISSORS = 2'b11;
  localparam logic [CODE_W-1:0] CODE_GAP      = 2'b10;
endpackage

// File: rtl/rps_encoder.sv
module rps_encoder
  import rps_pkg::*;
(
  input  logic [MOVE_W-1:0] move_i,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o
);
  always_comb begin
    code_o[1] = move_i[IDX_SCISSORS];
    code_o[0] = move_i[IDX_PAPER] | move_i[IDX_SCISSORS];
    err_o     = ($countones(move_i) != 1);
  end

  always_comb begin
    if (!err_o) begin
      p_gap_unused_r1: assert (code_o != CODE_GAP);
      if (move_i[IDX_ROCK])     p_rock_code_r1: assert (code_o == CODE_ROCK);
      if (move_i[IDX_PAPER])    p_paper_code_r1: assert (code_o == CODE_PAPER);
      if (move_i[IDX_SCISSORS]) p_sciss_code_r1: assert (code_o == CODE_SCISSORS);
    end
  end
endmodule

// File: rtl/rps_outcome.sv
module rps_outcome
  import rps_pkg::*;
(
  input  logic [CODE_W-1:0] a_code_i,
  input  logic [CODE_W-1:0] b_code_i,
  output logic              tie_o,
  output logic              a_win_o
);
  always_comb begin
    tie_o   = (a_code_i == b_code_i);
    // meaningful only for legal, unequal codes
    a_win_o = (~a_code_i[0] & b_code_i[1]) | ~(a_code_i[1] ^ b_code_i[0]);
  end

  always_comb begin
    if (a_code_i == CODE_ROCK && b_code_i == CODE_SCISSORS)
      p_rock_beats_sciss_r6: assert (a_win_o);
    if (a_code_i == CODE_PAPER && b_code_i == CODE_ROCK)
      p_paper_beats_rock_r6: assert (a_win_o);
    if (a_code_i == CODE_SCISSORS && b_code_i == CODE_PAPER)
      p_sciss_beats_paper_r6: assert (a_win_o);
  end
endmodule

// File: rtl/rps_judge.sv
module rps_judge
  import rps_pkg::*;
(
  input  logic [MOVE_W-1:0] a_move_i,
  input  logic [MOVE_W-1:0] b_move_i,
  input  logic              reveal_i,
  output logic              a_red_o,
  output logic              a_green_o,
  output logic              a_blue_o,
  output logic              b_red_o,
  output logic              b_green_o,
  output logic              b_blue_o
);
  logic [N_SIDES-1:0][MOVE_W-1:0] move;
  logic [N_SIDES-1:0][CODE_W-1:0] code;
  logic [N_SIDES-1:0]             err;
  logic                           tie;
  logic                           a_win;
  logic                           show;

  assign move[0] = a_move_i;
  assign move[1] = b_move_i;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    rps_encoder u_enc (
      .move_i (move[s]),
      .code_o (code[s]),
      .err_o  (err[s])
    );
  end

  rps_outcome u_outcome (
    .a_code_i (code[0]),
    .b_code_i (code[1]),
    .tie_o    (tie),
    .a_win_o  (a_win)
  );

  always_comb begin
    show      = ~|err & reveal_i;
    a_red_o   = err[0];
    b_red_o   = err[1];
    a_blue_o  = show & tie;
    b_blue_o  = show & tie;
    a_green_o = show & ~tie & a_win;
    b_green_o = show & ~tie & ~a_win;
  end

  always_comb begin
    if (!reveal_i)
      p_dark_unrevealed_r3: assert (!(a_green_o | b_green_o | a_blue_o | b_blue_o));
    if (a_red_o || b_red_o)
      p_dark_on_error_r4: assert (!(a_green_o | b_green_o | a_blue_o | b_blue_o));
    p_blue_pair_r5: assert (a_blue_o == b_blue_o);
    if (a_blue_o)
      p_no_green_on_tie_r5: assert (!(a_green_o | b_green_o));
    p_single_green_r7: assert (!(a_green_o && b_green_o));
    if (reveal_i && !a_red_o && !b_red_o && !a_blue_o)
      p_one_winner_r7: assert (a_green_o ^ b_green_o);
  end
endmodule

// File: tb/rps_judge_tb.sv
module rps_judge_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 2000;

  logic       clk = 1'b0;
  logic [2:0] a_move, b_move;
  logic       reveal;
  logic       a_red, a_green, a_blue, b_red, b_green, b_blue;
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rps_judge u_dut (
    .a_move_i  (a_move),
    .b_move_i  (b_move),
    .reveal_i  (reveal),
    .a_red_o   (a_red),
    .a_green_o (a_green),
    .a_blue_o  (a_blue),
    .b_red_o   (b_red),
    .b_green_o (b_green),
    .b_blue_o  (b_blue)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s a=%b b=%b rev=%b actual=%b expected=%b",
               req, what, a_move, b_move, reveal, act, exp);
    end
  endtask

  // index of a legal move: rock 0, paper 1, scissors 2 (bit position)
  function automatic int move_idx(input logic [2:0] m);
    for (int i = 0; i < 3; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic judge_round(input logic [2:0] am, input logic [2:0] bm, input logic rv);
    bit a_ok, b_ok, tie_e, a_wins;
    bit e_ag, e_bg, e_blue;
    string tag;
    @(posedge clk);
    a_move = am; b_move = bm; reveal = rv;
    @(negedge clk);
    a_ok   = ($countones(am) == 1);
    b_ok   = ($countones(bm) == 1);
    tie_e  = a_ok && b_ok && (am == bm);
    a_wins = a_ok && b_ok && !tie_e && (((move_idx(am) - move_idx(bm) + 3) % 3) == 1);
    e_blue = rv && a_ok && b_ok && tie_e;
    e_ag   = rv && a_ok && b_ok && !tie_e && a_wins;
    e_bg   = rv && a_ok && b_ok && !tie_e && !a_wins;
    check("R2", "a_red", a_red, !a_ok);
    check("R2", "b_red", b_red, !b_ok);
    if (!rv)                tag = "R3";
    else if (!a_ok || !b_ok) tag = "R4";
    else if (tie_e)         tag = "R5";
    else                    tag = "R1,R6";
    check(tag, "a_green", a_green, e_ag);
    check(tag, "b_green", b_green, e_bg);
    check(tag, "a_blue",  a_blue,  e_blue);
    check(tag, "b_blue",  b_blue,  e_blue);
    n_checks++;
    if ((a_green & b_green) || ((rv && a_ok && b_ok && !tie_e) && !(a_green ^ b_green))) begin
      n_fail++;
      $display("FAIL R7 green count a=%b b=%b rev=%b actual=%b%b expected=one-of",
               am, bm, rv, a_green, b_green);
    end
  endtask

  initial begin
    a_move = '0; b_move = '0; reveal = 1'b0;
    // idle state: no moves entered
    judge_round(3'b000, 3'b000, 1'b0);
    // named rule rows (R6): rock>scissors, paper>rock, scissors>paper, each side
    judge_round(3'b001, 3'b100, 1'b1);
    judge_round(3'b010, 3'b001, 1'b1);
    judge_round(3'b100, 3'b010, 1'b1);
    judge_round(3'b100, 3'b001, 1'b1);
    // R4: one side illegal but codes compress to a legal-looking pair
    judge_round(3'b110, 3'b100, 1'b1);
    // full sweep, both reveal levels
    for (int rv = 0; rv < 2; rv++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          judge_round(a[2:0], b[2:0], rv[0]);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule